// File: doc/BRIEF.md
# ADC Conversion Queue Sequencer

This block walks a table of conversion command words for two conversion queues and drives an abstract analog converter through a request/done handshake. Each command word carries a channel number and a pause bit. Software loads the table through a write port. Software or an external edge then starts a queue. The sequencer fetches words one at a time and asks for one conversion per word. It stops a pass when it meets an end-of-queue condition.

There are three sources of end-of-queue. The first is a word whose channel field is all ones (63). The second applies only while queue 1 runs: the pointer reaches queue 2's start entry. The third is the pointer running beyond the last table entry. Pause bits let a queue stop partway through and resume on its next trigger. Fixed precedence rules decide the outcome when a pause and an end-of-queue fall on the same entry or on neighbouring entries. Each queue runs in either single-scan or continuous-scan mode. Each queue keeps sticky pause and completion flags, which software clears by writing a one.

Top module: `adc_queue_seq`

## Requirements
- R1: After reset both queue status outputs read idle (00), all pause and completion flags are 0 and `conv_req_o` is low. A status output never reads 11; active is 01 and paused is 10.
- R2: Queue 1 starts at entry 0 and converts consecutive entries in order, with `conv_ch_o` equal to the entry's channel field. `conv_req_o` stays high with a stable channel until `conv_done_i` is sampled high, then drops for exactly one cycle while the next entry is fetched.
- R3: An entry whose channel field is 63 ends the pass without a conversion. The queue's completion flag is set and its status becomes idle.
- R4: While queue 1 runs, reaching the entry equal to `q2_start_i` ends queue 1's pass without converting that entry.
- R5: A queue that converts entry 63 without meeting another end-of-queue ends its pass there and sets its completion flag.
- R6: A trigger to queue 2 while `q2_start_i` is 64 or more sets queue 2's completion flag and leaves it idle, with no conversion.
- R7: An entry with its pause bit set is converted. If the next entry is not an end-of-queue, the pause flag is set and the status becomes paused (10). The next trigger resumes at the following entry.
- R8: A paused entry followed by an end-of-queue entry is converted, both flags are set, and the status becomes idle, not paused.
- R9: An entry that both has its pause bit set and gives end-of-queue is not converted. The pause flag stays 0, the completion flag is set, and the queue becomes idle.
- R10: Several end-of-queue conditions on one entry behave as one. With queue 2's start at 0 and entry 0 holding 63, a queue 1 trigger gives completion flag set, idle, and no conversion.
- R11: In continuous-scan mode (`cont_i` bit set) each end-of-queue sets the completion flag while the queue stays active and restarts at its start entry. Leaving the mode ends the queue at its next end-of-queue. A pass that ends before any conversion makes the queue idle even in continuous-scan mode.
- R12: A trigger to a queue that is active is ignored. A queue 2 trigger during queue 1 activity is held pending, while queue 2 still reads idle, and runs after queue 1 stops. Simultaneous triggers run queue 1 first.
- R13: Flags are sticky until a one is written to the matching bit of `pf_clr_i` or `cf_clr_i` (bit 0 queue 1, bit 1 queue 2).
- R14: An external trigger acts on its rising edge only. Holding it high does not start the queue again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Command table write enable |
| tbl_addr_i | input | 6 | Command table write address |
| tbl_ch_i | input | 6 | Channel field to write (63 = end-of-queue) |
| tbl_pause_i | input | 1 | Pause bit to write |
| q2_start_i | input | 7 | Queue 2 start entry (0 to 127) |
| cont_i | input | 2 | Continuous-scan select per queue (bit 0 queue 1) |
| sw_trig_i | input | 2 | Software trigger pulse per queue |
| ext_trig_i | input | 2 | External trigger level per queue, rising edge acts |
| pf_clr_i | input | 2 | Write-one-to-clear for pause flags |
| cf_clr_i | input | 2 | Write-one-to-clear for completion flags |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | 6 | Channel for the requested conversion |
| conv_done_i | input | 1 | Converter done pulse |
| pf_o | output | 2 | Pause flags per queue |
| cf_o | output | 2 | Completion flags per queue |
| q1_status_o | output | 2 | Queue 1 status: 00 idle, 01 active, 10 paused |
| q2_status_o | output | 2 | Queue 2 status, same encoding |

## Verification
The bench aims at the pause/end-of-queue precedence pairs. A design that checked pause before end-of-queue would convert the marker entry or leave the queue paused instead of idle. One scenario stacks all three end-of-queue sources on entry 0, where a design that counted conditions would set flags twice or convert a marker. The bench also runs past the last entry and triggers queue 2 with its start off the table, to catch a pointer that wraps to entry 0. Other cases cover queue 2 triggers arriving during queue 1 activity, external triggers held high, and continuous passes. A lost pending trigger, a retrigger on a level, or a continuous queue that drops to idle after one pass each shows up as a missing or unexpected channel in the scoreboard.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NQ = 2;

  typedef enum logic [1:0] {
    QS_IDLE   = 2'b00,
    QS_ACTIVE = 2'b01,
    QS_PAUSED = 2'b10
  } q_stat_e;

  typedef enum logic [1:0] {
    E_IDLE  = 2'b00,
    E_FETCH = 2'b01,
    E_CONV  = 2'b10
  } eng_st_e;
endpackage

// File: rtl/adc_seq_cmd_table.sv
module adc_seq_cmd_table #(
  parameter int ADDR_W = 6,
  parameter int CH_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CH_W-1:0]   wch_i,
  input  logic              wpause_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [CH_W-1:0]   rch_o,
  output logic              rpause_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CH_W-1:0]  ch_mem [DEPTH];
  logic [DEPTH-1:0] pause_mem;

  // empty table reads as end-of-queue everywhere
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_mem[e]    <= '1;
        pause_mem[e] <= 1'b0;
      end else if (we_i && (waddr_i == ADDR_W'(e))) begin
        ch_mem[e]    <= wch_i;
        pause_mem[e] <= wpause_i;
      end
    end
  end

  assign rch_o    = ch_mem[raddr_i];
  assign rpause_o = pause_mem[raddr_i];
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int NQ = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] sw_i,
  input  logic [NQ-1:0] ext_i,
  output logic [NQ-1:0] ev_o
);
  logic [NQ-1:0] ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= ext_i;
  end

  assign ev_o = sw_i | (ext_i & ~ext_q);
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CH_W   = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NQ-1:0]          ev_i,
  input  logic [NQ-1:0]          cont_i,
  input  logic [NQ-1:0]          pf_clr_i,
  input  logic [NQ-1:0]          cf_clr_i,
  input  logic [ADDR_W:0]        q2_start_i,
  output logic [ADDR_W-1:0]      rd_addr_o,
  input  logic [CH_W-1:0]        rd_ch_i,
  input  logic                   rd_pause_i,
  output logic                   conv_req_o,
  output logic [CH_W-1:0]        conv_ch_o,
  input  logic                   conv_done_i,
  output logic [NQ-1:0]          pf_o,
  output logic [NQ-1:0]          cf_o,
  output logic [NQ-1:0][1:0]     stat_o
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [CH_W-1:0] EOQ_CH = '1;

  eng_st_e          st_q;
  logic             cur_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] resume_q [NQ];
  q_stat_e          qst_q    [NQ];
  logic [NQ-1:0]    pend_q, pf_q, cf_q;
  logic             first_q, after_pause_q, pause_pend_q;
  logic [CH_W-1:0]  ch_q;

  logic             sel;
  logic [PTR_W-1:0] start_sel, start_cur;
  logic             hit_q2, eoq;

  assign sel       = pend_q[0] ? 1'b0 : 1'b1;
  assign start_sel = sel   ? q2_start_i : '0;
  assign start_cur = cur_q ? q2_start_i : '0;
  assign hit_q2    = !cur_q && (ptr_q == q2_start_i);
  // any source ends the pass; several at once act as one
  assign eoq       = ptr_q[PTR_W-1] | (rd_ch_i == EOQ_CH) | hit_q2;
  assign rd_addr_o = ptr_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= E_IDLE;
      cur_q         <= 1'b0;
      ptr_q         <= '0;
      pend_q        <= '0;
      pf_q          <= '0;
      cf_q          <= '0;
      first_q       <= 1'b0;
      after_pause_q <= 1'b0;
      pause_pend_q  <= 1'b0;
      ch_q          <= '0;
      for (int q = 0; q < NQ; q++) begin
        resume_q[q] <= '0;
        qst_q[q]    <= QS_IDLE;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (ev_i[q] && qst_q[q] != QS_ACTIVE) pend_q[q] <= 1'b1;
        if (pf_clr_i[q]) pf_q[q] <= 1'b0;
        if (cf_clr_i[q]) cf_q[q] <= 1'b0;
      end
      unique case (st_q)
        E_IDLE: begin
          if (|pend_q) begin
            cur_q         <= sel;
            pend_q[sel]   <= 1'b0;
            qst_q[sel]    <= QS_ACTIVE;
            after_pause_q <= 1'b0;
            if (qst_q[sel] == QS_PAUSED) begin
              ptr_q   <= resume_q[sel];
              first_q <= 1'b0;
            end else begin
              ptr_q   <= start_sel;
              first_q <= 1'b1;
            end
            st_q <= E_FETCH;
          end
        end
        E_FETCH: begin
          if (eoq) begin
            cf_q[cur_q] <= 1'b1;
            if (cont_i[cur_q] && !first_q) begin
              ptr_q         <= start_cur;
              first_q       <= 1'b1;
              after_pause_q <= 1'b0;
            end else begin
              qst_q[cur_q] <= QS_IDLE;
              st_q         <= E_IDLE;
            end
          end else if (after_pause_q) begin
            qst_q[cur_q]    <= QS_PAUSED;
            resume_q[cur_q] <= ptr_q;
            st_q            <= E_IDLE;
          end else begin
            ch_q         <= rd_ch_i;
            pause_pend_q <= rd_pause_i;
            first_q      <= 1'b0;
            st_q         <= E_CONV;
          end
        end
        E_CONV: begin
          if (conv_done_i) begin
            ptr_q         <= ptr_q + PTR_W'(1);
            after_pause_q <= pause_pend_q;
            if (pause_pend_q) pf_q[cur_q] <= 1'b1;
            st_q <= E_FETCH;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign conv_req_o = (st_q == E_CONV);
  assign conv_ch_o  = ch_q;
  assign pf_o       = pf_q;
  assign cf_o       = cf_q;

  for (genvar g = 0; g < NQ; g++) begin : g_stat
    assign stat_o[g] = qst_q[g];
  end
endmodule

// File: rtl/adc_queue_seq.sv
module adc_queue_seq
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CH_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [CH_W-1:0]   tbl_ch_i,
  input  logic              tbl_pause_i,
  input  logic [ADDR_W:0]   q2_start_i,
  input  logic [NQ-1:0]     cont_i,
  input  logic [NQ-1:0]     sw_trig_i,
  input  logic [NQ-1:0]     ext_trig_i,
  input  logic [NQ-1:0]     pf_clr_i,
  input  logic [NQ-1:0]     cf_clr_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  output logic [NQ-1:0]     pf_o,
  output logic [NQ-1:0]     cf_o,
  output logic [1:0]        q1_status_o,
  output logic [1:0]        q2_status_o
);
  logic [ADDR_W-1:0]  rd_addr;
  logic [CH_W-1:0]    rd_ch;
  logic               rd_pause;
  logic [NQ-1:0]      ev;
  logic [NQ-1:0][1:0] stat;

  adc_seq_cmd_table #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .waddr_i  (tbl_addr_i),
    .wch_i    (tbl_ch_i),
    .wpause_i (tbl_pause_i),
    .raddr_i  (rd_addr),
    .rch_o    (rd_ch),
    .rpause_o (rd_pause)
  );

  adc_seq_trig #(.NQ(NQ)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sw_i   (sw_trig_i),
    .ext_i  (ext_trig_i),
    .ev_o   (ev)
  );

  adc_seq_engine #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .cont_i      (cont_i),
    .pf_clr_i    (pf_clr_i),
    .cf_clr_i    (cf_clr_i),
    .q2_start_i  (q2_start_i),
    .rd_addr_o   (rd_addr),
    .rd_ch_i     (rd_ch),
    .rd_pause_i  (rd_pause),
    .conv_req_o  (conv_req_o),
    .conv_ch_o   (conv_ch_o),
    .conv_done_i (conv_done_i),
    .pf_o        (pf_o),
    .cf_o        (cf_o),
    .stat_o      (stat)
  );

  assign q1_status_o = stat[0];
  assign q2_status_o = stat[1];
endmodule

// File: rtl/adc_queue_seq_chk.sv
module adc_queue_seq_chk #(
  parameter int CH_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            conv_req_o,
  input logic [CH_W-1:0] conv_ch_o,
  input logic            conv_done_i,
  input logic [1:0]      pf_o,
  input logic [1:0]      cf_o,
  input logic [1:0]      pf_clr_i,
  input logic [1:0]      cf_clr_i,
  input logic [1:0]      q1_status_o,
  input logic [1:0]      q2_status_o
);
  AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q1_status_o != 2'b11) && (q2_status_o != 2'b11)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i) |=> (conv_req_o && $stable(conv_ch_o))); // R2

  AST_REQ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && conv_done_i) |=> !conv_req_o); // R2

  AST_NO_EOQ_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> (conv_ch_o != '1)); // R3

  AST_REQ_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> ((q1_status_o == 2'b01) || (q2_status_o == 2'b01))); // R12

  AST_SINGLE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((q1_status_o == 2'b01) && (q2_status_o == 2'b01))); // R12

  AST_CF1_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_o[0] && !cf_clr_i[0]) |=> cf_o[0]); // R13

  AST_CF2_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_o[1] && !cf_clr_i[1]) |=> cf_o[1]); // R13

  AST_PF1_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_o[0] && !pf_clr_i[0]) |=> pf_o[0]); // R13
endmodule

bind adc_queue_seq adc_queue_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_req_o  (conv_req_o),
  .conv_ch_o   (conv_ch_o),
  .conv_done_i (conv_done_i),
  .pf_o        (pf_o),
  .cf_o        (cf_o),
  .pf_clr_i    (pf_clr_i),
  .cf_clr_i    (cf_clr_i),
  .q1_status_o (q1_status_o),
  .q2_status_o (q2_status_o)
);

// File: tb/adc_queue_seq_bench.sv
`timescale 1ns/100ps
module adc_queue_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tbl_we_i = 1'b0;
  logic [5:0] tbl_addr_i = '0;
  logic [5:0] tbl_ch_i = '0;
  logic       tbl_pause_i = 1'b0;
  logic [6:0] q2_start_i = 7'd40;
  logic [1:0] cont_i = '0;
  logic [1:0] sw_trig_i = '0;
  logic [1:0] ext_trig_i = '0;
  logic [1:0] pf_clr_i = '0;
  logic [1:0] cf_clr_i = '0;
  logic       conv_req_o;
  logic [5:0] conv_ch_o;
  logic       conv_done_i = 1'b0;
  logic [1:0] pf_o, cf_o, q1_status_o, q2_status_o;

  adc_queue_seq u_adc_queue_seq (.*);

  always #2.5 clk_i = ~clk_i;

  int    n_chk = 0, n_fail = 0;
  int    cyc = 0;
  int    n_conv = 0;
  int    done_dly = 1;
  int    last_done = -1;
  bit    gap_chk = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R1";
  int    exp_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", r, act, exp);
    end
  endtask

  // monitor: compares each requested channel with the scoreboard and answers with done
  initial begin : monitor
    forever begin
      @(negedge clk_i);
      if (conv_req_o) begin
        if (gap_chk && last_done >= 0) chk("R2 gap", cyc - last_done, 2);
        if (exp_q.size() == 0) chk({cur_req, " unexpected conversion"}, int'(conv_ch_o), -1);
        else chk({cur_req, " channel"}, int'(conv_ch_o), exp_q.pop_front());
        repeat (done_dly - 1) @(negedge clk_i);
        conv_done_i = 1'b1;
        last_done = cyc;
        n_conv++;
        @(negedge clk_i);
        conv_done_i = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(int a, int ch, bit p);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_addr_i = 6'(a); tbl_ch_i = 6'(ch); tbl_pause_i = p;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic trig(logic [1:0] b);
    @(negedge clk_i); sw_trig_i = b;
    @(negedge clk_i); sw_trig_i = '0;
  endtask

  task automatic clr_all();
    @(negedge clk_i); pf_clr_i = 2'b11; cf_clr_i = 2'b11;
    @(negedge clk_i); pf_clr_i = '0; cf_clr_i = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
    while (q1_status_o == 2'b01 || q2_status_o == 2'b01 || exp_q.size() != 0 || conv_req_o)
      @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin : driver
    int base;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 q1 status", q1_status_o, 0);
    chk("R1 q2 status", q2_status_o, 0);
    chk("R1 flags", {pf_o, cf_o}, 0);
    chk("R1 req", conv_req_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 / R4: queue 1 stops at queue 2 start entry
    cur_req = "R2";
    q2_start_i = 7'd4;
    for (int i = 0; i < 4; i++) wr(i, 10 + i, 1'b0);
    wr(4, 20, 1'b0);
    for (int i = 0; i < 4; i++) exp_q.push_back(10 + i);
    gap_chk = 1'b1; last_done = -1;
    trig(2'b01);
    settle();
    gap_chk = 1'b0;
    chk("R4 cf q1", cf_o[0], 1);
    chk("R4 q1 idle", q1_status_o, 0);
    chk("R2 pf q1", pf_o[0], 0);

    // R13 sticky then write-one-to-clear
    repeat (5) @(negedge clk_i);
    chk("R13 cf held", cf_o[0], 1);
    cf_clr_i = 2'b01; @(negedge clk_i); cf_clr_i = '0;
    chk("R13 cf cleared", cf_o[0], 0);

    // R3 channel 63 marker
    cur_req = "R3";
    q2_start_i = 7'd40;
    wr(0, 5, 1'b0); wr(1, 6, 1'b0); wr(2, 63, 1'b0);
    exp_q.push_back(5); exp_q.push_back(6);
    trig(2'b01);
    settle();
    chk("R3 cf q1", cf_o[0], 1);
    chk("R3 q1 idle", q1_status_o, 0);
    clr_all();

    // R7 pause then resume
    cur_req = "R7";
    wr(0, 7, 1'b1); wr(1, 8, 1'b0);
    exp_q.push_back(7);
    trig(2'b01);
    settle();
    chk("R7 paused", q1_status_o, 2);
    chk("R7 pf", pf_o[0], 1);
    chk("R7 cf", cf_o[0], 0);
    pf_clr_i = 2'b01; @(negedge clk_i); pf_clr_i = '0;
    chk("R13 pf cleared", pf_o[0], 0);
    exp_q.push_back(8);
    trig(2'b01);
    settle();
    chk("R7 resumed done", cf_o[0], 1);
    chk("R7 idle", q1_status_o, 0);
    clr_all();

    // R8 pause then end-of-queue on next entry
    cur_req = "R8";
    wr(0, 9, 1'b1); wr(1, 63, 1'b0);
    exp_q.push_back(9);
    trig(2'b01);
    settle();
    chk("R8 flags", {pf_o[0], cf_o[0]}, 3);
    chk("R8 idle not paused", q1_status_o, 0);
    clr_all();

    // R9 pause and end-of-queue on the same entry
    cur_req = "R9";
    wr(0, 63, 1'b1);
    trig(2'b01);
    settle();
    chk("R9 pf", pf_o[0], 0);
    chk("R9 cf", cf_o[0], 1);
    chk("R9 idle", q1_status_o, 0);
    clr_all();

    // R10 stacked end-of-queue sources
    cur_req = "R10";
    q2_start_i = 7'd0;
    wr(0, 63, 1'b0);
    trig(2'b01);
    settle();
    chk("R10 cf", cf_o[0], 1);
    chk("R10 idle", q1_status_o, 0);
    clr_all();

    // R6 queue 2 start beyond table
    cur_req = "R6";
    q2_start_i = 7'd70;
    trig(2'b10);
    settle();
    chk("R6 cf q2", cf_o[1], 1);
    chk("R6 q2 idle", q2_status_o, 0);
    clr_all();

    // R5 / R14 run past entry 63, external edge, level held
    cur_req = "R5";
    q2_start_i = 7'd61;
    wr(61, 1, 1'b0); wr(62, 2, 1'b0); wr(63, 3, 1'b0);
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    @(negedge clk_i); ext_trig_i = 2'b10;
    settle();
    chk("R5 cf q2", cf_o[1], 1);
    cur_req = "R14";
    repeat (12) @(negedge clk_i);
    chk("R14 no retrigger", q2_status_o, 0);
    chk("R14 no extra conv", exp_q.size(), 0);
    ext_trig_i = '0;
    clr_all();

    // R12 queue 2 pending during queue 1, active retrigger ignored
    cur_req = "R12";
    done_dly = 3;
    wr(0, 20, 1'b0); wr(1, 21, 1'b0); wr(2, 63, 1'b0);
    exp_q.push_back(20); exp_q.push_back(21);
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    trig(2'b01);
    repeat (3) @(negedge clk_i);
    trig(2'b10);
    chk("R12 q2 pending reads idle", q2_status_o, 0);
    trig(2'b01);
    settle();
    chk("R12 both done", cf_o, 3);
    clr_all();
    // simultaneous triggers: queue 1 first
    exp_q.push_back(20); exp_q.push_back(21);
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    trig(2'b11);
    settle();
    chk("R12 simultaneous done", cf_o, 3);
    done_dly = 1;
    clr_all();

    // R11 continuous scan
    cur_req = "R11";
    wr(0, 30, 1'b0); wr(1, 31, 1'b0);
    cont_i = 2'b01;
    for (int i = 0; i < 3; i++) begin exp_q.push_back(30); exp_q.push_back(31); end
    base = n_conv;
    trig(2'b01);
    wait (n_conv == base + 3);
    @(negedge clk_i);
    chk("R11 cf after pass", cf_o[0], 1);
    chk("R11 still active", q1_status_o, 1);
    wait (n_conv == base + 5);
    @(negedge clk_i);
    cont_i = 2'b00;
    settle();
    chk("R11 stops after mode off", q1_status_o, 0);
    chk("R11 all passes", n_conv - base, 6);
    clr_all();
    // empty pass in continuous mode
    cont_i = 2'b01;
    wr(0, 63, 1'b0);
    trig(2'b01);
    settle();
    chk("R11 empty pass idle", q1_status_o, 0);
    chk("R11 empty pass cf", cf_o[0], 1);
    cont_i = 2'b00;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule